// File: doc/BRIEF.md
# Single-cycle 4-bit accumulator processor

This block is a small accumulator processor. It completes one 8-bit instruction in every clock. The program counter addresses a 16-word instruction store, and the store is read combinationally. A decoder turns the upper four bits of the word into control signals. The ALU combines the accumulator with the lower four bits of the word. The accumulator, the flag pair and the program counter all update together on the next rising edge.

The store is filled through a plain synchronous write port, normally while reset is held. After reset is released, execution starts at address 0. The accumulator, the program counter and both flags are brought out as observation outputs.

The block has no streaming interface. The program port is a simple write strobe that is accepted on every clock edge, so it never exerts back-pressure.

Top module: `scpu_core`

## Requirements
- R1: While `rst_i` is high at a rising edge, the PC, the accumulator and both flags become 0 and stay 0. The first instruction after reset is taken from address 0.
- R2: A write with `prog_we_i` high stores `prog_data_i` at `prog_addr_i` on the rising edge. The word at address `pc_o` is executed in the same cycle. In that word, bits [7:4] are the opcode and bits [3:0] are the operand.
- R3: Every opcode except jumps and halt advances the PC by 1, wrapping from 15 to 0. Halt (1111) keeps the PC, the accumulator and the flags unchanged.
- R4: Load-immediate (0001) copies the operand into the accumulator and leaves both flags unchanged.
- R5: Add (0010) sets the accumulator to (acc + operand) mod 16. Carry becomes bit 4 of the 5-bit sum. Zero is set when the 4-bit result is 0.
- R6: Subtract (0011) sets the accumulator to (acc − operand) mod 16. Carry is set exactly when acc < operand. Zero is set when the 4-bit result is 0.
- R7: AND (0100), OR (0101) and XOR (0110) combine the accumulator with the operand. Invert (0111) writes ~acc and ignores the operand. All four clear carry and set zero from the result.
- R8: Jump (1000) loads the operand into the PC. It leaves the accumulator and the flags unchanged.
- R9: Jump-if-zero (1001) and jump-if-carry (1010) test the registered flag. When the flag is set, the PC takes the operand; otherwise the PC advances by 1. Neither changes the accumulator or the flags.
- R10: Opcode 0000 and the unused opcodes 1011 to 1110 only advance the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| prog_we_i | input | 1 | Instruction store write strobe |
| prog_addr_i | input | 4 | Instruction store write address |
| prog_data_i | input | 8 | Instruction word to store |
| acc_o | output | 4 | Accumulator value |
| pc_o | output | 4 | Program counter |
| zero_o | output | 1 | Registered zero flag |
| carry_o | output | 1 | Registered carry/borrow flag |

## Verification
Each result is due one rising edge after the instruction is presented. The instruction is visible combinationally as soon as the PC settles. The PC, the accumulator and the flags therefore all reflect an instruction at the first edge after it is fetched.

The bench keeps a reference model of the processor state and advances it by exactly one instruction per clock. It then samples all four outputs on the falling edge that follows each rising edge. A program write takes effect at its own edge, so the bench finishes loading the store before it releases reset and starts stepping.

// File: rtl/scpu_pkg.sv
package scpu_pkg;
  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP = 4'h0, OP_LDI = 4'h1, OP_ADD = 4'h2, OP_SUB = 4'h3,
    OP_AND = 4'h4, OP_OR  = 4'h5, OP_XOR = 4'h6, OP_NOT = 4'h7,
    OP_JMP = 4'h8, OP_JZ  = 4'h9, OP_JC  = 4'hA, OP_HLT = 4'hF
  } opcode_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOT
  } alu_op_e;

  typedef struct packed {
    logic    acc_we;
    logic    imm_sel;
    logic    flag_we;
    logic    pc_load;
    logic    pc_hold;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/scpu_pc.sv
module scpu_pc #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         load_i,
  input  logic         hold_i,
  input  logic [W-1:0] target_i,
  output logic [W-1:0] pc_o
);
  logic [W-1:0] pc_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)       pc_q <= '0;
    else if (load_i) pc_q <= target_i;
    else if (!hold_i) pc_q <= pc_q + W'(1);
  end

  assign pc_o = pc_q;

  p_step_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (!load_i && !hold_i) |=> pc_q == W'($past(pc_q) + W'(1)));
  p_halt_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (hold_i && !load_i) |=> $stable(pc_q));
  p_jump_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i |=> pc_q == $past(target_i));
endmodule

// File: rtl/scpu_imem.sv
module scpu_imem #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/scpu_alu.sv
module scpu_alu
  import scpu_pkg::*;
#(
  parameter int W = 4
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         zero_o,
  output logic         carry_o
);
  logic [W:0] sum, diff;

  assign sum  = {1'b0, a_i} + {1'b0, b_i};
  assign diff = {1'b0, a_i} - {1'b0, b_i};

  always_comb begin
    carry_o = 1'b0;
    case (op_i)
      ALU_ADD: begin res_o = sum[W-1:0];  carry_o = sum[W];  end
      ALU_SUB: begin res_o = diff[W-1:0]; carry_o = diff[W]; end
      ALU_AND: res_o = a_i & b_i;
      ALU_OR:  res_o = a_i | b_i;
      ALU_XOR: res_o = a_i ^ b_i;
      default: res_o = ~a_i;
    endcase
  end

  assign zero_o = (res_o == '0);

  always_comb begin
    if (op_i == ALU_SUB)
      p_borrow_r6: assert (carry_o == (a_i < b_i));
  end
endmodule

// File: rtl/scpu_decode.sv
module scpu_decode
  import scpu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             zero_i,
  input  logic             carry_i,
  output ctrl_t            ctrl_o
);
  always_comb begin
    ctrl_o = '{acc_we: 1'b0, imm_sel: 1'b0, flag_we: 1'b0,
               pc_load: 1'b0, pc_hold: 1'b0, alu_op: ALU_ADD};
    case (opcode_i)
      OP_LDI: begin ctrl_o.acc_we = 1'b1; ctrl_o.imm_sel = 1'b1; end
      OP_ADD: begin ctrl_o.acc_we = 1'b1; ctrl_o.flag_we = 1'b1; ctrl_o.alu_op = ALU_ADD; end
      OP_SUB: begin ctrl_o.acc_we = 1'b1; ctrl_o.flag_we = 1'b1; ctrl_o.alu_op = ALU_SUB; end
      OP_AND: begin ctrl_o.acc_we = 1'b1; ctrl_o.flag_we = 1'b1; ctrl_o.alu_op = ALU_AND; end
      OP_OR:  begin ctrl_o.acc_we = 1'b1; ctrl_o.flag_we = 1'b1; ctrl_o.alu_op = ALU_OR;  end
      OP_XOR: begin ctrl_o.acc_we = 1'b1; ctrl_o.flag_we = 1'b1; ctrl_o.alu_op = ALU_XOR; end
      OP_NOT: begin ctrl_o.acc_we = 1'b1; ctrl_o.flag_we = 1'b1; ctrl_o.alu_op = ALU_NOT; end
      OP_JMP: ctrl_o.pc_load = 1'b1;
      OP_JZ:  ctrl_o.pc_load = zero_i;
      OP_JC:  ctrl_o.pc_load = carry_i;
      OP_HLT: ctrl_o.pc_hold = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    p_ctl_excl_r10: assert ($onehot0({ctrl_o.acc_we, ctrl_o.pc_load, ctrl_o.pc_hold}));
  end
endmodule

// File: rtl/scpu_core.sv
module scpu_core
  import scpu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 prog_we_i,
  input  logic [W-1:0]         prog_addr_i,
  input  logic [OPC_W+W-1:0]   prog_data_i,
  output logic [W-1:0]         acc_o,
  output logic [W-1:0]         pc_o,
  output logic                 zero_o,
  output logic                 carry_o
);
  localparam int IW = OPC_W + W;

  logic [IW-1:0]    instr;
  logic [OPC_W-1:0] opcode;
  logic [W-1:0]     operand, pc, alu_res, acc_d, acc_q;
  logic             alu_zero, alu_carry, zero_q, carry_q;
  ctrl_t            ctrl;

  scpu_pc #(.W(W)) u_pc (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(ctrl.pc_load),
    .hold_i(ctrl.pc_hold), .target_i(operand), .pc_o(pc)
  );

  scpu_imem #(.AW(W), .DW(IW)) u_imem (
    .clk_i(clk_i), .we_i(prog_we_i), .waddr_i(prog_addr_i),
    .wdata_i(prog_data_i), .raddr_i(pc), .rdata_o(instr)
  );

  assign opcode  = instr[IW-1:W];
  assign operand = instr[W-1:0];

  scpu_decode u_dec (
    .opcode_i(opcode), .zero_i(zero_q), .carry_i(carry_q), .ctrl_o(ctrl)
  );

  scpu_alu #(.W(W)) u_alu (
    .op_i(ctrl.alu_op), .a_i(acc_q), .b_i(operand),
    .res_o(alu_res), .zero_o(alu_zero), .carry_o(alu_carry)
  );

  assign acc_d = ctrl.imm_sel ? operand : alu_res;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      acc_q   <= '0;
      zero_q  <= 1'b0;
      carry_q <= 1'b0;
    end else begin
      if (ctrl.acc_we)  acc_q <= acc_d;
      if (ctrl.flag_we) begin
        zero_q  <= alu_zero;
        carry_q <= alu_carry;
      end
    end
  end

  assign acc_o   = acc_q;
  assign pc_o    = pc;
  assign zero_o  = zero_q;
  assign carry_o = carry_q;

  p_reset_r1: assert property (@(posedge clk_i)
    rst_i |=> (pc_o == '0 && acc_o == '0 && !zero_o && !carry_o));
  p_ldi_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (ctrl.acc_we && ctrl.imm_sel) |=> acc_q == $past(operand));
  p_acc_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    !ctrl.acc_we |=> $stable(acc_q));
  p_flag_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    !ctrl.flag_we |=> ($stable(zero_q) && $stable(carry_q)));
  p_logic_clear_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (ctrl.flag_we && ctrl.alu_op != ALU_ADD && ctrl.alu_op != ALU_SUB) |=> !carry_q);
endmodule

// File: tb/scpu_core_tb.sv
module scpu_core_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       we = 1'b0;
  logic [3:0] waddr = '0;
  logic [7:0] wdata = '0;
  logic [3:0] acc, pc;
  logic       zf, cf;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] prog [16];
  logic [3:0] m_pc, m_acc;
  logic       m_z, m_c;
  string      m_tag;

  always #10 clk = ~clk;

  scpu_core u_dut (
    .clk_i(clk), .rst_i(rst), .prog_we_i(we), .prog_addr_i(waddr),
    .prog_data_i(wdata), .acc_o(acc), .pc_o(pc), .zero_o(zf), .carry_o(cf)
  );

  task automatic check(input string tag);
    checks++;
    if (pc !== m_pc || acc !== m_acc || zf !== m_z || cf !== m_c) begin
      failures++;
      $display("FAIL %s: pc/acc/z/c actual %h/%h/%b/%b expected %h/%h/%b/%b",
               tag, pc, acc, zf, cf, m_pc, m_acc, m_z, m_c);
    end
  endtask

  // Reference model: advance one instruction from the requirement text.
  task automatic model_step();
    logic [3:0] op, k, npc;
    logic [4:0] s;
    op = prog[m_pc][7:4];
    k = prog[m_pc][3:0];
    npc = m_pc + 4'd1;
    m_tag = "R10";
    case (op)
      4'h1: begin m_acc = k; m_tag = "R4"; end
      4'h2: begin s = {1'b0, m_acc} + {1'b0, k}; m_acc = s[3:0]; m_c = s[4];
                  m_z = (s[3:0] == 0); m_tag = "R5"; end
      4'h3: begin m_c = (m_acc < k); m_acc = m_acc - k; m_z = (m_acc == 0); m_tag = "R6"; end
      4'h4: begin m_acc = m_acc & k; m_c = 0; m_z = (m_acc == 0); m_tag = "R7"; end
      4'h5: begin m_acc = m_acc | k; m_c = 0; m_z = (m_acc == 0); m_tag = "R7"; end
      4'h6: begin m_acc = m_acc ^ k; m_c = 0; m_z = (m_acc == 0); m_tag = "R7"; end
      4'h7: begin m_acc = ~m_acc; m_c = 0; m_z = (m_acc == 0); m_tag = "R7"; end
      4'h8: begin npc = k; m_tag = "R8"; end
      4'h9: begin if (m_z) npc = k; m_tag = "R9"; end
      4'hA: begin if (m_c) npc = k; m_tag = "R9"; end
      4'hF: begin npc = m_pc; m_tag = "R3"; end
      default: ;
    endcase
    m_pc = npc;
  endtask

  task automatic load_and_start();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 16; i++) begin
      we = 1'b1; waddr = 4'(i); wdata = prog[i];
      @(negedge clk);
    end
    we = 1'b0;
    rst = 1'b0;
    m_pc = 0; m_acc = 0; m_z = 0; m_c = 0;
    check("R1");
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      model_step();
      @(posedge clk);
      @(negedge clk);
      check({m_tag, "/R2"});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // Directed program: SUB underflow, taken/not-taken JZ and JC, jump loop.
    prog = '{8'h13, 8'h35, 8'hA5, 8'h00, 8'h00, 8'h22, 8'h99, 8'h00,
             8'h00, 8'h14, 8'h44, 8'h90, 8'hA0, 8'h64, 8'hB7, 8'h8D};
    load_and_start();
    run(40);

    // R2: rewrite word 0 under reset and see it executed first.
    prog[0] = 8'h19;
    load_and_start();
    run(1);
    if (acc !== 4'h9) begin
      failures++;
      $display("FAIL R2: acc actual %h expected 9", acc);
    end
    checks++;

    // Sweep every ALU opcode over every accumulator/operand pair, then halt.
    for (int op = 2; op <= 7; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          for (int i = 0; i < 16; i++) prog[i] = 8'hF0;
          prog[0] = {4'h1, 4'(a)};
          prog[1] = {4'(op), 4'(b)};
          load_and_start();
          run(4);
        end

    // Arithmetic pseudo-random programs exercise every opcode and wrap.
    for (int seed = 0; seed < 12; seed++) begin
      for (int i = 0; i < 16; i++)
        prog[i] = 8'((i * 73 + seed * 29 + 5) ^ (i << 3) ^ (seed << 5));
      load_and_start();
      run(48);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule